// File: doc/BRIEF.md
# Banked GPIO Controller with Edge/Level Interrupts

This block is a 32-pin general-purpose I/O peripheral. The pins are grouped into four banks of eight, and every bank decodes the same set of word registers inside its own 64-byte window. Each bank has its own direction, output data, sampled input, interrupt status, interrupt mask and per-pin detection mode. The block drives the pad output values and output enables. It samples the pad inputs through a two-stage synchroniser and raises one combined interrupt line.

Software reaches the registers over a minimal word bus with byte address, write data, a write strobe and a read strobe. Reads are combinational and appear in the same cycle as the read strobe. Writes take effect at the next clock edge. Only the low eight data bits carry meaning, and unused upper read bits return zero. Mask bits are set and cleared through two separate write offsets, so one pin's mask can change without a read-modify-write.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: Byte address bits [7:6] select the bank and bits [5:2] select the word register. Pin p belongs to bank p/8, bit p%8, so pin 10 is bit 2 of bank 1.
- R2: Offset 0x10 holds the direction. A 1 makes the pin an input with its pad_oe bit low. A 0 makes it an output with pad_oe high. pad_out carries the output register of offset 0x14.
- R3: Offset 0x14 is a read/write output data register. Only write data bits [7:0] are stored, and read bits [31:8] return zero.
- R4: Offset 0x18 returns the pad levels after two flops, whatever the pin's direction. Writes to offset 0x18 change nothing.
- R5: Offset 0x04 reads the raw interrupt status. A write to it clears each status bit whose write data bit is 1.
- R6: Offset 0x00 is read-only and returns the raw status ANDed with the inverted mask.
- R7: Offset 0x08 reads the mask, where 1 means masked. Writing 1s to offset 0x08 masks those pins and writing 1s to offset 0x0C unmasks them. Writing 0xFF to offset 0x08 masks the whole bank.
- R8: Offset 0x20 is a read/write mode register. A 1 selects level detection and a 0 selects rising-edge detection.
- R9: In edge mode, a rising edge of the synchronised input sets the status bit on the third clock edge after the pad changes. A steady high input does not set it again once it is cleared.
- R10: In level mode, the status bit is set while the synchronised input is high. A clear has no effect while the input stays high. The bit stays set after the input falls, until it is cleared.
- R11: When a clear write and a new detection event hit the same status bit in the same cycle, the bit ends up set.
- R12: irq is the OR of the masked status of all banks.
- R13: After reset, direction is 0xFF, output is 0x00, mask is 0xFF, mode is 0x00 and status is 0x00 in every bank, and irq is low.
- R14: Reads of offset 0x0C and of offsets with no register return zero. bus_rdata is zero whenever bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 = drive |
| irq | output | 1 | Combined interrupt |

## Verification
The bench reads the input register and the raw status in the exact cycles around the synchroniser and detection latency. A design with the wrong stage count would show the pad level, or the status bit, one cycle early or late. A level-mode pin is cleared while its input is held high, and again after the input falls. A design that treated it as edge mode, or that cleared its status unconditionally, would read back zero while the input is still high. A clear write is aimed at the very cycle in which a rising edge is detected, so a design that gives the clear priority loses the event. Separate mask and unmask writes, writes to the read-only input register, and reads of write-only or empty offsets catch swapped polarity and decode leakage between banks.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // word offsets inside a 64-byte bank window (byte offset >> 2)
   localparam logic [3:0] OFF_MSTAT  = 4'h0;
   localparam logic [3:0] OFF_RSTAT  = 4'h1;
   localparam logic [3:0] OFF_MASK   = 4'h2;
   localparam logic [3:0] OFF_UNMASK = 4'h3;
   localparam logic [3:0] OFF_DIR    = 4'h4;
   localparam logic [3:0] OFF_DOUT   = 4'h5;
   localparam logic [3:0] OFF_DIN    = 4'h6;
   localparam logic [3:0] OFF_MODE   = 4'h8;
   localparam int unsigned WIN_BITS  = 6;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [3:0]   off,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_sync,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] dout_q,
   output logic [W-1:0] rdata,
   output logic         bank_irq
);
   logic [W-1:0] mask_q, mode_q, stat_q, prev_q;
   logic [W-1:0] edge_evt, lvl_evt, evt, clr, masked;

   assign edge_evt = pin_sync & ~prev_q & ~mode_q;
   assign lvl_evt  = pin_sync & mode_q;
   assign evt      = edge_evt | lvl_evt;
   assign clr      = (wr_en && off == OFF_RSTAT) ? wdata : '0;
   assign masked   = stat_q & ~mask_q;
   assign bank_irq = |masked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         dout_q <= '0;
         mask_q <= '1;
         mode_q <= '0;
         stat_q <= '0;
         prev_q <= '0;
      end else begin
         prev_q <= pin_sync;
         stat_q <= (stat_q & ~clr) | evt;
         if (wr_en) begin
            case (off)
               OFF_DIR:    dir_q  <= wdata;
               OFF_DOUT:   dout_q <= wdata;
               OFF_MASK:   mask_q <= mask_q | wdata;
               OFF_UNMASK: mask_q <= mask_q & ~wdata;
               OFF_MODE:   mode_q <= wdata;
               default:    ;
            endcase
         end
      end
   end

   always_comb begin
      case (off)
         OFF_MSTAT: rdata = masked;
         OFF_RSTAT: rdata = stat_q;
         OFF_MASK:  rdata = mask_q;
         OFF_DIR:   rdata = dir_q;
         OFF_DOUT:  rdata = dout_q;
         OFF_DIN:   rdata = pin_sync;
         OFF_MODE:  rdata = mode_q;
         default:   rdata = '0;
      endcase
   end

   // R9
   edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_evt != '0) |=> ((stat_q & $past(edge_evt)) == $past(edge_evt)));
   // R10
   level_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_evt != '0) |=> ((stat_q & $past(lvl_evt)) == $past(lvl_evt)));
   // R5
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr != '0) |=> ((stat_q & $past(clr & ~evt)) == '0));
   // R7
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == OFF_MASK) |=> ((mask_q & $past(wdata)) == $past(wdata)));
   // R7
   unmask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == OFF_UNMASK) |=> ((mask_q & $past(wdata)) == '0));
endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 4,
   parameter int unsigned BANK_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NPINS      = NUM_BANKS * BANK_W,
   localparam int unsigned SEL_W      = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq
);
   if (NUM_BANKS < 2 || (1 << SEL_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (BANK_W > DATA_W) begin : g_bad_width
      $error("BANK_W must not exceed DATA_W");
   end
   if (ADDR_W != SEL_W + WIN_BITS) begin : g_bad_addr
      $error("ADDR_W must equal bank select bits plus window bits");
   end

   logic [SEL_W-1:0] bank_sel;
   logic [3:0]       off;
   logic [NPINS-1:0] pin_sync;
   logic [BANK_W-1:0] bank_rd [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_irq;
   logic unused_bits;

   assign bank_sel    = bus_addr[ADDR_W-1:WIN_BITS];
   assign off         = bus_addr[WIN_BITS-1:2];
   assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:BANK_W]};

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BANK_W-1:0] dir_q;
      logic [BANK_W-1:0] dout_q;

      gpio_bank #(.W(BANK_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bus_we && bank_sel == SEL_W'(b)),
         .off      (off),
         .wdata    (bus_wdata[BANK_W-1:0]),
         .pin_sync (pin_sync[b*BANK_W +: BANK_W]),
         .dir_q    (dir_q),
         .dout_q   (dout_q),
         .rdata    (bank_rd[b]),
         .bank_irq (bank_irq[b])
      );

      assign pad_out[b*BANK_W +: BANK_W] = dout_q;
      assign pad_oe[b*BANK_W +: BANK_W]  = ~dir_q;
   end

   assign irq       = |bank_irq;
   assign bus_rdata = bus_re ? DATA_W'(bank_rd[bank_sel]) : '0;

   // R14
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_re) |-> (bus_rdata == '0));
endmodule

// File: tb/banked_gpio_ctrl_bench.sv
`timescale 1ns/1ps
module banked_gpio_ctrl_bench;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 0;
   logic        bus_re = 0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic        irq;
   int vec_cnt = 0;
   int bad_cnt = 0;
   logic [31:0] v;

   always #4 clk = ~clk;

   banked_gpio_ctrl u_banked_gpio_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // {req[3:0], we, addr[7:0], wdata[31:0], expected[31:0]}
   localparam int NV = 24;
   localparam logic [76:0] VEC [NV] = '{
      {4'd13, 1'b0, 8'h10, 32'h0, 32'hFF},      // R13 dir reset bank0
      {4'd13, 1'b0, 8'h90, 32'h0, 32'hFF},      // R13 dir reset bank2
      {4'd13, 1'b0, 8'h08, 32'h0, 32'hFF},      // R13 mask reset
      {4'd13, 1'b0, 8'hC8, 32'h0, 32'hFF},      // R13 mask reset bank3
      {4'd13, 1'b0, 8'h14, 32'h0, 32'h00},      // R13 output reset
      {4'd13, 1'b0, 8'h20, 32'h0, 32'h00},      // R13 mode reset
      {4'd13, 1'b0, 8'h04, 32'h0, 32'h00},      // R13 status reset
      {4'd2,  1'b1, 8'h50, 32'hFFFF_FF0F, 32'h0},
      {4'd2,  1'b0, 8'h50, 32'h0, 32'h0F},      // R2 dir bank1
      {4'd1,  1'b0, 8'h10, 32'h0, 32'hFF},      // R1 bank0 untouched
      {4'd3,  1'b1, 8'h54, 32'h1234_56A5, 32'h0},
      {4'd3,  1'b0, 8'h54, 32'h0, 32'hA5},      // R3 upper bits dropped
      {4'd4,  1'b1, 8'h18, 32'hFF, 32'h0},
      {4'd4,  1'b0, 8'h14, 32'h0, 32'h00},      // R4 input write ignored
      {4'd7,  1'b1, 8'hCC, 32'h81, 32'h0},
      {4'd7,  1'b0, 8'hC8, 32'h0, 32'h7E},      // R7 unmask
      {4'd7,  1'b1, 8'hC8, 32'h01, 32'h0},
      {4'd7,  1'b0, 8'hC8, 32'h0, 32'h7F},      // R7 mask sets only bit0
      {4'd14, 1'b0, 8'hCC, 32'h0, 32'h00},      // R14 write-only reads 0
      {4'd14, 1'b0, 8'h1C, 32'h0, 32'h00},      // R14 hole reads 0
      {4'd8,  1'b1, 8'hA0, 32'h3C, 32'h0},
      {4'd8,  1'b0, 8'hA0, 32'h0, 32'h3C},      // R8 mode readback
      {4'd7,  1'b1, 8'hC8, 32'hFF, 32'h0},
      {4'd7,  1'b0, 8'hC8, 32'h0, 32'hFF}       // R7 0xFF masks bank
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vec_cnt++;
      if (act !== exp) begin
         bad_cnt++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic rd_now(input logic [7:0] a, output logic [31:0] r);
      bus_addr = a; bus_re = 1;
      #1 r = bus_rdata;
      bus_re = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] r);
      @(negedge clk);
      rd_now(a, r);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad_cnt++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R13 irq after reset", {31'b0, irq}, 32'h0);
      chk("R13 pad_oe after reset", pad_oe, 32'h0);
      chk("R13 pad_out after reset", pad_out, 32'h0);
      #1 chk("R14 idle rdata", bus_rdata, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
         else begin
            rd(VEC[i][71:64], v);
            chk($sformatf("R%0d vec %0d", VEC[i][76:73], i), v, VEC[i][31:0]);
         end
      end

      @(negedge clk);
      chk("R2 pad_oe from dir", pad_oe, 32'h0000_F000);
      chk("R2 pad_out from output", pad_out, 32'h0000_A500);

      // edge detection latency and pin mapping
      @(negedge clk);
      pad_in = 32'h0000_045A;
      @(negedge clk);
      @(negedge clk);
      rd_now(8'h18, v); chk("R4 input after two flops", v, 32'h5A);
      rd_now(8'h58, v); chk("R1 pin 10 is bank1 bit2", v, 32'h04);
      rd_now(8'h04, v); chk("R9 status not yet set", v, 32'h00);
      @(negedge clk);
      rd_now(8'h04, v); chk("R9 rising edge sets status", v, 32'h5A);
      rd_now(8'h00, v); chk("R6 masked status all masked", v, 32'h00);
      chk("R7 irq low while masked", {31'b0, irq}, 32'h0);
      wr(8'h0C, 32'h02);
      rd(8'h00, v); chk("R6 masked status after unmask", v, 32'h02);
      chk("R12 irq from bank0", {31'b0, irq}, 32'h1);
      wr(8'h04, 32'hFF);
      rd(8'h04, v); chk("R5 write-one clears", v, 32'h00);
      repeat (2) @(negedge clk);
      rd(8'h04, v); chk("R9 steady high no retrigger", v, 32'h00);
      chk("R12 irq drops", {31'b0, irq}, 32'h0);
      wr(8'h08, 32'hFF);

      // level mode in bank2 (mode bits 0x3C)
      wr(8'h8C, 32'hFF);
      @(negedge clk);
      pad_in[18] = 1'b1;
      repeat (3) @(negedge clk);
      rd(8'h84, v); chk("R10 level sets status", v, 32'h04);
      chk("R12 irq from bank2", {31'b0, irq}, 32'h1);
      wr(8'h84, 32'h04);
      rd(8'h84, v); chk("R10 clear blocked while high", v, 32'h04);
      pad_in[18] = 1'b0;
      repeat (3) @(negedge clk);
      rd(8'h84, v); chk("R10 sticky after fall", v, 32'h04);
      wr(8'h84, 32'h04);
      rd(8'h84, v); chk("R10 clears once low", v, 32'h00);
      wr(8'h88, 32'hFF);

      // clear write colliding with a new edge event
      pad_in = '0;
      repeat (3) @(negedge clk);
      wr(8'h04, 32'hFF);
      rd(8'h04, v); chk("R5 bank0 cleared", v, 32'h00);
      @(negedge clk);
      pad_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 8'h04; bus_wdata = 32'h01; bus_we = 1;
      @(negedge clk);
      bus_we = 0;
      rd_now(8'h04, v); chk("R11 event beats clear", v, 32'h01);

      finish_run();
   end
endmodule